// File: doc/BRIEF.md
# Command Completion Counter with Acknowledge Handshake

This block sits in one channel of a multi-channel transfer engine. It counts completed-command events in a free-running 6-bit done counter. Software reads a 32-bit status word, handles the events, and acknowledges them by writing back the done value it has consumed into a processed field. Software never writes a one to clear a bit. The number of events still waiting is the modulo-64 distance between the two counters, so wrap-around needs no special care and an event that arrives during an acknowledge write is never lost.

A second word holds the channel's interrupt configuration. There are two enables, one for per-command events and one for list events; either of them arms the interrupt. A mode bit selects the interrupt style. In level mode the interrupt line stays high for as long as unacknowledged events remain. In pulse mode it produces one cycle per event. An interrupt-active flag shows that an event arrived since the last acknowledge. A channel cancel clears that flag but keeps both counters, so software can resynchronise after aborting a transfer.

Top module: `cmd_done_tracker`

## Requirements
- R1: After reset, both words read as zero and `irq_o` is low.
- R2: Each cycle with `evt_i` high adds one to the done count in bits [5:0] of word 0. The count wraps from 63 to 0, and no other input changes it.
- R3: A write to word 0 (`bus_addr`=0) loads bits [21:16] of the write data into the processed count. Bits [5:0] of the write data are ignored.
- R4: The pending count is (done − processed) mod 64. A pending count that has crossed the wrap (for example done 2, processed 60) still counts as outstanding.
- R5: Bit 8 of word 0 is set by every event. It is cleared by any write to word 0. An event in the same cycle as the write leaves it set.
- R6: An event in the same cycle as an acknowledge write still increments the done count, and the level interrupt stays high.
- R7: In level mode (word 1 bit 28 = 1) with the interrupt armed, `irq_o` is high in the cycle after done and processed differ, and low in the cycle after they are equal.
- R8: The interrupt is armed when word 1 bit 29 (per-command enable) or bit 31 (list enable) is set. With both bits clear, `irq_o` stays low.
- R9: In pulse mode (bit 28 = 0) with the interrupt armed, `irq_o` is high for exactly the one cycle that follows each clock edge that registers an event.
- R10: Word 1 (`bus_addr`=1) stores bits 31, 29 and 28 and reads them back. All other bits of word 1 read as zero. Writes to word 1 leave the counters unchanged.
- R11: A cycle with `cancel_i` high clears bit 8 and leaves both counters and the level interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | One-cycle command-completion event |
| cancel_i | input | 1 | Channel cancel pulse |
| bus_addr | input | 1 | Word select: 0 status/acknowledge, 1 configuration |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected word (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hazardous overlap is an event that arrives in the same clock cycle as the acknowledge write. The bench provokes it by raising `evt_i` and the write strobe together, with the write carrying the done value software last saw. It then expects the done count to be one ahead of the processed count, the active flag to be set, and the level interrupt to remain asserted. The bench also pairs cancel with a pending event and confirms that the counters survive and the interrupt stays high.

// File: rtl/cmd_trk_pkg.sv
package cmd_trk_pkg;
  // field positions that software decodes
  localparam int unsigned PROC_LSB  = 16;
  localparam int unsigned FLAG_BIT  = 8;
  localparam int unsigned LEVEL_BIT = 28;
  localparam int unsigned CIEN_BIT  = 29;
  localparam int unsigned LIEN_BIT  = 31;

  typedef struct packed {
    logic list_ien;
    logic cmd_ien;
    logic level;
  } irq_cfg_t;

  typedef enum logic {
    WORD_STATUS = 1'b0,
    WORD_CONFIG = 1'b1
  } word_sel_e;
endpackage

// File: rtl/cmd_cnt_core.sv
module cmd_cnt_core #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             cancel_i,
  input  logic             ack_wr,
  input  logic [CNT_W-1:0] ack_val,
  output logic [CNT_W-1:0] done_cnt,
  output logic [CNT_W-1:0] proc_cnt,
  output logic             act_flag,
  output logic             pending_nz
);
  // modulo distance between producer and consumer counts
  function automatic logic [CNT_W-1:0] pending_of(input logic [CNT_W-1:0] d,
                                                  input logic [CNT_W-1:0] p);
    return d - p;
  endfunction

  logic [CNT_W-1:0] pending;
  assign pending    = pending_of(done_cnt, proc_cnt);
  assign pending_nz = |pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_cnt <= '0;
      proc_cnt <= '0;
      act_flag <= 1'b0;
    end else begin
      if (evt_i)  done_cnt <= done_cnt + 1'b1;
      if (ack_wr) proc_cnt <= ack_val;
      if (evt_i)                  act_flag <= 1'b1;
      else if (ack_wr || cancel_i) act_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_irq_gen.sv
module cmd_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic irq_en,
  input  logic pending_nz,
  input  logic evt_i,
  output logic irq_o
);
  logic irq_cond;
  assign irq_cond = irq_en && (level_mode ? pending_nz : evt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_cond;
  end
endmodule

// File: rtl/cmd_reg_if.sv
module cmd_reg_if
  import cmd_trk_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  done_cnt,
  input  logic [CNT_W-1:0]  proc_cnt,
  input  logic              act_flag,
  output logic              ack_wr,
  output logic [CNT_W-1:0]  ack_val,
  output irq_cfg_t          cfg,
  output logic [DATA_W-1:0] bus_rdata
);
  word_sel_e sel;
  assign sel     = word_sel_e'(bus_addr);
  assign ack_wr  = bus_wr && (sel == WORD_STATUS);
  assign ack_val = bus_wdata[PROC_LSB +: CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (bus_wr && sel == WORD_CONFIG) begin
      cfg.level    <= bus_wdata[LEVEL_BIT];
      cfg.cmd_ien  <= bus_wdata[CIEN_BIT];
      cfg.list_ien <= bus_wdata[LIEN_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel == WORD_STATUS) begin
      bus_rdata[0 +: CNT_W]        = done_cnt;
      bus_rdata[FLAG_BIT]          = act_flag;
      bus_rdata[PROC_LSB +: CNT_W] = proc_cnt;
    end else begin
      bus_rdata[LEVEL_BIT] = cfg.level;
      bus_rdata[CIEN_BIT]  = cfg.cmd_ien;
      bus_rdata[LIEN_BIT]  = cfg.list_ien;
    end
  end
endmodule

// File: rtl/cmd_done_tracker.sv
module cmd_done_tracker
  import cmd_trk_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic              cancel_i,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic [CNT_W-1:0] done_cnt, proc_cnt, ack_val;
  logic             act_flag, pending_nz, ack_wr, irq_en;
  irq_cfg_t         cfg;

  assign irq_en = cfg.cmd_ien | cfg.list_ien;

  cmd_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cancel_i(cancel_i),
    .ack_wr(ack_wr), .ack_val(ack_val), .done_cnt(done_cnt),
    .proc_cnt(proc_cnt), .act_flag(act_flag), .pending_nz(pending_nz)
  );

  cmd_reg_if #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .done_cnt(done_cnt), .proc_cnt(proc_cnt),
    .act_flag(act_flag), .ack_wr(ack_wr), .ack_val(ack_val), .cfg(cfg),
    .bus_rdata(bus_rdata)
  );

  cmd_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .level_mode(cfg.level), .irq_en(irq_en),
    .pending_nz(pending_nz), .evt_i(evt_i), .irq_o(irq_o)
  );
endmodule

// File: rtl/cmd_done_tracker_chk.sv
module cmd_done_tracker_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_i,
  input logic             cancel_i,
  input logic             ack_wr,
  input logic [CNT_W-1:0] ack_val,
  input logic [CNT_W-1:0] done_cnt,
  input logic [CNT_W-1:0] proc_cnt,
  input logic             act_flag,
  input logic             irq_en,
  input logic             level_mode,
  input logic             irq_o
);
  // R2
  done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> done_cnt == CNT_W'($past(done_cnt) + 1'b1));
  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> $stable(done_cnt));
  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> proc_cnt == $past(ack_val));
  // R11
  proc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> $stable(proc_cnt));
  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> act_flag);
  // R11
  cancel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_i && !evt_i) |=> !act_flag);
  // R7
  level_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && irq_en && done_cnt != proc_cnt) |=> irq_o);
  // R7
  level_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && done_cnt == proc_cnt) |=> !irq_o);
  // R8
  disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_o);
  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && irq_en) |=> (irq_o == $past(evt_i)));
endmodule

bind cmd_done_tracker cmd_done_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cancel_i(cancel_i),
  .ack_wr(ack_wr), .ack_val(ack_val), .done_cnt(done_cnt),
  .proc_cnt(proc_cnt), .act_flag(act_flag), .irq_en(irq_en),
  .level_mode(cfg.level), .irq_o(irq_o)
);

// File: tb/cmd_done_tracker_bench.sv
module cmd_done_tracker_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_i = 1'b0;
  logic        cancel_i = 1'b0;
  logic        bus_addr = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_done_tracker u_cmd_done_tracker (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cancel_i(cancel_i),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // status word layout: done [5:0], flag bit 8, processed [21:16]
  function automatic logic [31:0] stat(input int done, input int proc, input bit flag);
    return (32'(proc % 64) << 16) | (32'(flag) << 8) | 32'(done % 64);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input bit addr, input logic [31:0] exp);
    bus_addr = addr;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic wr(input bit addr, input logic [31:0] data);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      evt_i = 1'b1;
      tick();
    end
    evt_i = 1'b0;
  endtask

  task automatic t_reset();
    read_chk("R1 status", 1'b0, 32'h0);
    read_chk("R1 config", 1'b1, 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
  endtask

  task automatic t_count();
    wr(1'b1, 32'h3000_0000);
    events(3);
    read_chk("R2 count", 1'b0, stat(3, 0, 1));
    check("R7 level high", 32'(irq_o), 32'h1);
  endtask

  task automatic t_ack();
    wr(1'b0, (32'd3 << 16) | 32'h0000_012A);
    read_chk("R3 ack load", 1'b0, stat(3, 3, 0));
    check("R7 still high one cycle", 32'(irq_o), 32'h1);
    tick();
    check("R7 low after equal", 32'(irq_o), 32'h0);
  endtask

  task automatic t_collide();
    bus_addr = 1'b0; bus_wdata = 32'd3 << 16; bus_wr = 1'b1; evt_i = 1'b1;
    tick();
    bus_wr = 1'b0; evt_i = 1'b0; bus_wdata = '0;
    read_chk("R6 increment kept", 1'b0, stat(4, 3, 1));
    tick();
    check("R6 irq kept", 32'(irq_o), 32'h1);
    wr(1'b0, 32'd4 << 16);
    tick();
    check("R7 low after ack", 32'(irq_o), 32'h0);
  endtask

  task automatic t_wrap();
    events(62);
    read_chk("R2 wrap", 1'b0, stat(2, 4, 1));
    wr(1'b0, 32'd60 << 16);
    read_chk("R5 flag clr", 1'b0, stat(2, 60, 0));
    tick();
    check("R4 wrapped pending", 32'(irq_o), 32'h1);
    wr(1'b0, 32'd2 << 16);
    tick();
    check("R4 zero pending", 32'(irq_o), 32'h0);
  endtask

  task automatic t_enable();
    wr(1'b1, 32'h1000_0000);
    events(1);
    tick();
    check("R8 disarmed", 32'(irq_o), 32'h0);
    wr(1'b1, 32'h9000_0000);
    tick();
    check("R8 list enable", 32'(irq_o), 32'h1);
    wr(1'b0, 32'd3 << 16);
    tick();
  endtask

  task automatic t_edge();
    wr(1'b1, 32'h2000_0000);
    tick();
    events(1);
    check("R9 pulse", 32'(irq_o), 32'h1);
    tick();
    check("R9 one cycle", 32'(irq_o), 32'h0);
    wr(1'b0, 32'd4 << 16);
  endtask

  task automatic t_cfg();
    wr(1'b1, 32'hFFFF_FFFF);
    read_chk("R10 config", 1'b1, 32'hB000_0000);
    read_chk("R10 counters untouched", 1'b0, stat(4, 4, 0));
  endtask

  task automatic t_cancel();
    wr(1'b1, 32'h3000_0000);
    events(1);
    cancel_i = 1'b1;
    tick();
    cancel_i = 1'b0;
    read_chk("R11 cancel", 1'b0, stat(5, 4, 0));
    tick();
    check("R11 irq kept", 32'(irq_o), 32'h1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_count();
    t_ack();
    t_collide();
    t_wrap();
    t_enable();
    t_edge();
    t_cfg();
    t_cancel();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule